// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block receives asynchronous serial frames that carry a ninth flag bit used to mark address (station ID) frames on a shared multi-drop line. Each frame has a low start bit, eight data bits sent least significant bit first, the flag bit and one high stop bit. Between frames the line rests high.

Software can arm a wake-up filter. While it is armed, the receiver drops every frame whose flag bit is 0 and leaves its data register and flags untouched. The first frame with the flag bit at 1 is loaded like a normal frame and raises the receive interrupt. Loading it also disarms the filter, so the data frames that follow arrive normally. If the ID does not belong to this station, software arms the filter again and the rest of that message is skipped in hardware.

Software reaches the block through a small register port: a control register (filter arm and interrupt enable), a data register, and a status register with write-one-to-clear flags. The bit period is set by a clock-divider parameter with 16x oversampling.

Top module: `mprxTop`

## Requirements
- R1: A frame is a 0 start bit, data bits D0 to D7 in that order, a flag bit and a stop bit, each lasting 16 oversample ticks. After a good frame is loaded, address 1 reads the data byte and bit 0 (full) of status address 2 reads 1.
- R2: With control bit 0 (filter) at 0, every frame with a good stop bit is loaded whatever its flag bit is. Status bit 3 then reads the flag bit of the loaded frame.
- R3: With the filter at 1, a frame whose flag bit is 0 is dropped: the data register, all status bits and the interrupt output stay unchanged.
- R4: With the filter at 1, a frame whose flag bit is 1 is loaded, sets the full bit and raises the interrupt when it is enabled.
- R5: Loading a frame clears control bit 0 (filter) to 0.
- R6: Writing address 0 sets control bit 0 (filter) and bit 1 (interrupt enable) from write data bits 0 and 1. Writing address 2 with a 1 in bit 0, 1 or 2 clears full, overrun or framing error.
- R7: A low pulse on the idle line that is high again at the middle of the start bit does not start a frame, and the receiver still takes the next real frame.
- R8: A frame whose stop bit reads 0 sets status bit 2 (framing error). The data register, full bit and interrupt stay unchanged.
- R9: A good, unfiltered frame that ends while full is 1 sets status bit 1 (overrun) and leaves the data register unchanged.
- R10: Output irqOut is 1 exactly when full is 1 and control bit 1 (interrupt enable) is 1.
- R11: After reset, all control and status bits, the data register and irqOut are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Serial receive line, rests high |
| regAddr | input | 2 | Register select: 0 control, 1 data, 2 status |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 3 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| irqOut | output | 1 | Receive interrupt level |

## Verification
Data bytes with a single 1 bit in each position, a single 0 bit in each position, and the all-zero and all-one bytes are sent, once with each flag value. These patterns show whether the bits are ordered correctly and whether any bit is stuck. With the filter armed, a run of flag-0 frames that must vanish alternates with a flag-1 frame that must land and disarm the filter. This shows whether the filter looks at the correct bit and whether it clears itself. Separate runs use a bad stop bit, a second frame before the first is read, a short low glitch, and the interrupt enable off. These show that the error paths and the interrupt gating are kept apart from a normal load.

// File: rtl/mprxPkg.sv
package mprxPkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } rxStateT;

  typedef struct packed {
    logic shiftEn;    // a data or flag bit is sampled this cycle
    logic bitVal;     // value of the sampled bit
    logic frameDone;  // stop bit sampled this cycle
    logic stopBad;    // stop bit read as 0
  } rxStrobeT;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/mprxCtrl.sv
module mprxCtrl
  import mprxPkg::*;
#(
  parameter int DIV   = 2,
  parameter int OVS   = 16,
  parameter int NBITS = 9
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxLine,
  output rxStrobeT strobe
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int OVS_W = $clog2(OVS);
  localparam int BIT_W = $clog2(NBITS);
  localparam logic [OVS_W-1:0] MID_CNT  = OVS_W'(OVS / 2 - 1);
  localparam logic [OVS_W-1:0] LAST_CNT = OVS_W'(OVS - 1);

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  rxStateT          state;
  logic [OVS_W-1:0] ovsCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             rxPrev;

  assign tick = (divCnt == DIV_W'(DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      ovsCnt <= '0;
      bitCnt <= '0;
      rxPrev <= 1'b1;
    end else if (tick) begin
      rxPrev <= rxLine;
      unique case (state)
        ST_IDLE: begin
          if (rxPrev && !rxLine) begin
            state  <= ST_START;
            ovsCnt <= '0;
          end
        end
        ST_START: begin
          if (ovsCnt == MID_CNT) begin
            ovsCnt <= '0;
            bitCnt <= '0;
            state  <= rxLine ? ST_IDLE : ST_BITS;
          end else begin
            ovsCnt <= ovsCnt + 1'b1;
          end
        end
        ST_BITS: begin
          if (ovsCnt == LAST_CNT) begin
            ovsCnt <= '0;
            if (bitCnt == BIT_W'(NBITS - 1)) state <= ST_STOP;
            else bitCnt <= bitCnt + 1'b1;
          end else begin
            ovsCnt <= ovsCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (ovsCnt == LAST_CNT) begin
            ovsCnt <= '0;
            state  <= ST_IDLE;
          end else begin
            ovsCnt <= ovsCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.bitVal    = rxLine;
    strobe.shiftEn   = tick && (state == ST_BITS) && (ovsCnt == LAST_CNT);
    strobe.frameDone = tick && (state == ST_STOP) && (ovsCnt == LAST_CNT);
    strobe.stopBad   = strobe.frameDone && !rxLine;
  end

  // R7: a start bit that reads high at mid-bit returns the receiver to idle
  a_r7_glitch_reject: assert property (@(posedge clk) disable iff (!rstN)
    (tick && state == ST_START && ovsCnt == MID_CNT && rxLine) |=> (state == ST_IDLE));

  // R1: sampling a bit and ending a frame never happen in the same cycle
  a_r1_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.shiftEn && strobe.frameDone));
endmodule

// File: rtl/mprxDatapath.sv
module mprxDatapath
  import mprxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobeT          strobe,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [2:0]        regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  localparam int SHIFT_W = DATA_W + 1;

  logic [SHIFT_W-1:0] shiftReg;
  logic [DATA_W-1:0]  dataReg;
  logic               filterEn, irqEn;
  logic               fullFlag, overrunFlag, framingFlag, mpStat;
  logic               frameMp, frameDropped, frameOverrun, frameLoad;

  assign frameMp      = shiftReg[SHIFT_W-1];
  assign frameDropped = strobe.frameDone && !strobe.stopBad && filterEn && !frameMp;
  assign frameOverrun = strobe.frameDone && !strobe.stopBad && !frameDropped && fullFlag;
  assign frameLoad    = strobe.frameDone && !strobe.stopBad && !frameDropped && !fullFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {strobe.bitVal, shiftReg[SHIFT_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg     <= '0;
      filterEn    <= 1'b0;
      irqEn       <= 1'b0;
      fullFlag    <= 1'b0;
      overrunFlag <= 1'b0;
      framingFlag <= 1'b0;
      mpStat      <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_CTRL) begin
        filterEn <= regWrData[0];
        irqEn    <= regWrData[1];
      end
      if (regWrEn && regAddr == ADDR_STAT) begin
        if (regWrData[0]) fullFlag    <= 1'b0;
        if (regWrData[1]) overrunFlag <= 1'b0;
        if (regWrData[2]) framingFlag <= 1'b0;
      end
      if (strobe.frameDone && strobe.stopBad) framingFlag <= 1'b1;
      if (frameOverrun) overrunFlag <= 1'b1;
      if (frameLoad) begin
        dataReg  <= shiftReg[DATA_W-1:0];
        fullFlag <= 1'b1;
        mpStat   <= frameMp;
        filterEn <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdData = DATA_W'({irqEn, filterEn});
      ADDR_DATA: regRdData = dataReg;
      ADDR_STAT: regRdData = DATA_W'({mpStat, framingFlag, overrunFlag, fullFlag});
      default:   regRdData = '0;
    endcase
  end

  assign irqOut = fullFlag & irqEn;

  // R3: a filtered frame leaves data and full flag untouched
  a_r3_drop_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    (frameDropped && !regWrEn) |=> ($stable(dataReg) && $stable(fullFlag) && $stable(irqOut)));

  // R5: a loaded frame disarms the filter
  a_r5_load_disarms: assert property (@(posedge clk) disable iff (!rstN)
    frameLoad |=> (!filterEn && fullFlag));

  // R8: a bad stop bit flags a framing error and keeps the data
  a_r8_framing_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && strobe.stopBad) |=> (framingFlag && $stable(dataReg)));

  // R9: a frame landing on a full register raises overrun and keeps the data
  a_r9_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    frameOverrun |=> (overrunFlag && $stable(dataReg)));
endmodule

// File: rtl/mprxTop.sv
module mprxTop #(
  parameter int DIV    = 2,
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [2:0]        regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  localparam int NBITS = DATA_W + 1;

  logic [1:0]       rxSync;
  mprxPkg::rxStrobeT strobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSync <= 2'b11;
    else rxSync <= {rxSync[0], rxIn};
  end

  mprxCtrl #(.DIV(DIV), .OVS(OVS), .NBITS(NBITS)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .rxLine (rxSync[1]),
    .strobe (strobe)
  );

  mprxDatapath #(.DATA_W(DATA_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

  // R11: interrupt is low straight after reset is released
  a_r11_reset_quiet: assert property (@(posedge clk)
    $rose(rstN) |-> !irqOut);
endmodule

// File: tb/sim_mprxTop.sv
module sim_mprxTop;
  localparam int DIV     = 2;
  localparam int BIT_CLK = DIV * 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic [2:0] regWrData = 3'd0;
  logic [7:0] regRdData;
  logic       irqOut;

  int checks = 0;
  int errors = 0;

  // reference state computed from the requirements
  logic       mFilt = 0, mIrqEn = 0, mFull = 0, mOvr = 0, mFe = 0, mMp = 0;
  logic [7:0] mData = 0;

  always #4 clk = ~clk;

  mprxTop #(.DIV(DIV)) u0 (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [2:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 2'd0) begin mFilt = d[0]; mIrqEn = d[1]; end
    if (a == 2'd2) begin
      if (d[0]) mFull = 0;
      if (d[1]) mOvr = 0;
      if (d[2]) mFe = 0;
    end
  endtask

  task automatic driveBit(input logic b);
    @(negedge clk);
    rxIn = b;
    repeat (BIT_CLK - 1) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic mp, input logic stopV);
    driveBit(1'b0);
    for (int i = 0; i < 8; i++) driveBit(d[i]);
    driveBit(mp);
    driveBit(stopV);
    @(negedge clk);
    rxIn = 1'b1;
    repeat (BIT_CLK) @(negedge clk);
    // reference update
    if (!stopV) mFe = 1;
    else if (mFilt && !mp) begin end
    else if (mFull) mOvr = 1;
    else begin mData = d; mFull = 1; mMp = mp; mFilt = 0; end
  endtask

  task automatic checkAll(input string tag);
    logic [7:0] v;
    regRead(2'd0, v); check({tag, " ctrl"}, v, {6'd0, mIrqEn, mFilt});
    regRead(2'd1, v); check({tag, " data"}, v, mData);
    regRead(2'd2, v); check({tag, " status"}, v, {4'd0, mMp, mFe, mOvr, mFull});
    #1 check({tag, " irq"}, {7'd0, irqOut}, {7'd0, mFull & mIrqEn});
  endtask

  function automatic logic [7:0] pattern(input int i);
    if (i < 8) return 8'(1 << i);
    if (i < 16) return ~8'(1 << (i - 8));
    if (i == 16) return 8'h00;
    return 8'hFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkAll("R11 reset");

    regWrite(2'd0, 3'b010);
    checkAll("R6 irq enable write");

    // filter off: every frame loads, flag bit recorded
    for (int mp = 0; mp < 2; mp++) begin
      for (int i = 0; i < 18; i++) begin
        sendFrame(pattern(i), 1'(mp), 1'b1);
        checkAll("R1 R2 R10 unfiltered load");
        regWrite(2'd2, 3'b001);
        checkAll("R6 clear full");
      end
    end

    // filter on: flag-0 frames vanish, flag-1 frame lands and disarms
    for (int i = 0; i < 8; i++) begin
      regWrite(2'd0, 3'b011);
      checkAll("R6 arm filter");
      sendFrame(pattern(i + 8), 1'b0, 1'b1);
      checkAll("R3 filtered drop");
      sendFrame(pattern(i), 1'b1, 1'b1);
      checkAll("R4 R5 id accept");
      sendFrame(pattern(i + 8), 1'b0, 1'b1);
      checkAll("R2 data after id, overrun R9");
      regWrite(2'd2, 3'b011);
    end

    // overrun
    sendFrame(8'h3C, 1'b0, 1'b1);
    sendFrame(8'hC3, 1'b1, 1'b1);
    checkAll("R9 overrun keeps data");
    regWrite(2'd2, 3'b011);
    checkAll("R6 clear overrun");

    // framing error
    sendFrame(8'h96, 1'b0, 1'b0);
    checkAll("R8 framing error");
    regWrite(2'd2, 3'b100);
    checkAll("R6 clear framing");

    // glitch on the idle line
    @(negedge clk);
    rxIn = 1'b0;
    repeat (4) @(negedge clk);
    rxIn = 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
    checkAll("R7 glitch ignored");
    sendFrame(8'h5A, 1'b1, 1'b1);
    checkAll("R7 frame after glitch");
    regWrite(2'd2, 3'b001);

    // interrupt gated off
    regWrite(2'd0, 3'b000);
    sendFrame(8'hE7, 1'b0, 1'b1);
    checkAll("R10 irq disabled");
    regWrite(2'd0, 3'b010);
    checkAll("R10 irq enabled");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule